// File: doc/BRIEF.md
# Selectable-Rate Pulse-Width Modulator

This block produces one pulse-width modulated output from a single free-running 8-bit counter. The counter advances once per slow-rate tick, a single-cycle clock enable pulse that stands for a 32 kHz time base. A 2-bit rate select chooses which counter bit, once it becomes set, sends the counter back to zero. The bits below that bit form the active count, so the four settings give periods of 128, 64, 32 or 16 ticks: 250 Hz, 500 Hz, 1 kHz or 2 kHz. A faster rate leaves fewer steps of duty resolution.

Software drives the block through a plain synchronous 8-bit register port. The control register at offset 0 holds a run bit and the rate select. The level register at offset 1 holds a 7-bit duty value. The two registers are written separately, and neither update is held back until a period boundary. A new duty value changes the comparison on the next clock. A rate change leaves the counter where it is, so the period in progress may be irregular.

Top module: `prate_pwm`

## Requirements
- R1: After reset both registers read as zero, the output is low and the count is zero.
- R2: While the run bit (control bit 7) is clear, the output is low and the counter is held at zero. Once the bit is set, counting starts from zero.
- R3: The counter moves only in a cycle where the tick input is high. Without a tick it keeps its value.
- R4: With rate select s (control bits [1:0]), a tick that would set counter bit 7−s clears the counter instead, so a period lasts 2^(7−s) ticks.
- R5: While running, the output is high when the active count (counter bits below bit 7−s) is less than the duty value, and low otherwise. A duty value of 0 keeps the output low.
- R6: A duty value at or above full scale 2^(7−s) keeps the output high. At s=0 the largest duty value, 127, still leaves one low tick in every 128.
- R7: A duty write takes effect in the cycle right after the write, without waiting for a period boundary.
- R8: Changing the rate select does not clear the counter. Counting continues from the present value under the new reset bit.
- R9: A read strobe loads rdata on the next clock. At offset 0 it loads {run, 5'b0, select}, at offset 1 it loads {1'b0, duty}, and at offsets 2 and 3 it loads zero. Without a strobe, rdata holds its value.
- R10: Writes to offsets 2 and 3 change neither register. Unused control bits (6:2) and duty bit 7 are not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Single-cycle enable at the counting rate |
| addr_i | input | 2 | Register offset |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| pwm_o | output | 1 | Modulated output |

## Verification
The assertions assume that the tick input is a clean synchronous enable and that the address is stable in every cycle that carries a read or write strobe. They put no limit on how often ticks come, and they let a write arrive in the same cycle as a tick. The stimulus drives all inputs on the falling edge and never leaves a strobe or the address undefined. It runs ticks on every cycle and on sparse patterns, and it changes the rate and duty in the middle of a period. This exercises the cases where the counter sits above the new reset bit.

// File: rtl/prate_pkg.sv
package prate_pkg;
  localparam int CNT_W  = 8;
  localparam int PS_W   = 2;
  localparam int DUTY_W = CNT_W - 1;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int RUN_BIT = DATA_W - 1;
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_DUTY = ADDR_W'(1);

  // index of the counter bit that restarts the count
  function automatic int top_bit(input logic [PS_W-1:0] ps);
    return CNT_W - 1 - int'(ps);
  endfunction

  function automatic logic [CNT_W-1:0] active_mask(input logic [PS_W-1:0] ps);
    return CNT_W'((1 << top_bit(ps)) - 1);
  endfunction

  function automatic logic [CNT_W-1:0] full_scale(input logic [PS_W-1:0] ps);
    return CNT_W'(1 << top_bit(ps));
  endfunction

  // next counter value on a tick
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] cnt,
                                                  input logic [PS_W-1:0]  ps);
    logic [CNT_W-1:0] nxt;
    nxt = cnt + CNT_W'(1);
    if ((nxt & full_scale(ps)) != '0) nxt = '0;
    return nxt;
  endfunction
endpackage

// File: rtl/prate_regs.sv
module prate_regs
  import prate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              run_o,
  output logic [PS_W-1:0]   ps_o,
  output logic [DUTY_W-1:0] duty_o
);
  logic wr_ctrl, wr_duty;
  logic [DATA_W-1:0] rd_mux;

  assign wr_ctrl = wr_en_i && (addr_i == OFS_CTRL);
  assign wr_duty = wr_en_i && (addr_i == OFS_DUTY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_o  <= 1'b0;
      ps_o   <= '0;
      duty_o <= '0;
    end else begin
      if (wr_ctrl) begin
        run_o <= wdata_i[RUN_BIT];
        ps_o  <= wdata_i[PS_W-1:0];
      end
      if (wr_duty) duty_o <= wdata_i[DUTY_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == OFS_CTRL) begin
      rd_mux[RUN_BIT]    = run_o;
      rd_mux[PS_W-1:0]   = ps_o;
    end else if (addr_i == OFS_DUTY) begin
      rd_mux[DUTY_W-1:0] = duty_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  assert_other_ofs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i != OFS_CTRL && addr_i != OFS_DUTY)
      |=> ($stable(run_o) && $stable(ps_o) && $stable(duty_o)));

  assert_duty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == OFS_DUTY) |=> (rdata_o == {1'b0, $past(duty_o)}));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/prate_counter.sv
module prate_counter
  import prate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [PS_W-1:0]  ps_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_evt
);
  logic [CNT_W-1:0] stepped;

  assign stepped  = step_count(count_o, ps_i);
  assign wrap_evt = run_i && tick_i && (stepped == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_o <= '0;
    else if (!run_i) count_o <= '0;
    else if (tick_i) count_o <= stepped;
  end

  assert_hold_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (count_o == '0));

  assert_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick_i) |=> $stable(count_o));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (count_o == '0));
endmodule

// File: rtl/prate_compare.sv
module prate_compare
  import prate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [PS_W-1:0]   ps_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);
  logic [CNT_W-1:0] active;
  logic             below;

  assign active = count_i & active_mask(ps_i);
  assign below  = active < CNT_W'(duty_i);
  assign pwm_o  = run_i && below;

  assert_zero_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_i == '0) |-> !pwm_o);

  assert_full_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && CNT_W'(duty_i) >= full_scale(ps_i)) |-> pwm_o);

  assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !pwm_o);
endmodule

// File: rtl/prate_pwm.sv
module prate_pwm
  import prate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pwm_o
);
  logic              run;
  logic [PS_W-1:0]   ps;
  logic [DUTY_W-1:0] duty;
  logic [CNT_W-1:0]  count;
  logic              wrap_evt;

  prate_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o),
    .run_o(run), .ps_o(ps), .duty_o(duty)
  );

  prate_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(run), .ps_i(ps), .tick_i(tick_i),
    .count_o(count), .wrap_evt(wrap_evt)
  );

  prate_compare u_cmp (
    .clk(clk), .rst_n(rst_n), .run_i(run), .ps_i(ps), .count_i(count),
    .duty_i(duty), .pwm_o(pwm_o)
  );

  // a prescaler change alone never clears the counter
  assert_keep_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick_i && wr_en_i && addr_i == OFS_CTRL && wdata_i[RUN_BIT])
      |=> $stable(count));
endmodule

// File: tb/tb_prate_pwm.sv
module tb_prate_pwm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       rd_en_i = 1'b0;
  logic [7:0] rdata_o;
  logic       pwm_o;

  int n_run = 0, n_fail = 0, cyc = 0;
  int tick_div = 1;
  string req = "R1";

  // behavioural reference state
  int m_run = 0, m_ps = 0, m_duty = 0, m_cnt = 0, m_rd = 0;

  prate_pwm dut (.*);

  always #5 clk = ~clk;

  task automatic check(input string r, input int act, input int exp, input string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", r, what, act, exp, cyc);
    end
  endtask

  function automatic int m_pwm();
    int period = 128 >> m_ps;
    return (m_run != 0 && (m_cnt % period) < m_duty) ? 1 : 0;
  endfunction

  // reference model advances on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_ps = 0; m_duty = 0; m_cnt = 0; m_rd = 0;
    end else begin
      int period, n;
      period = 128 >> m_ps;
      if (rd_en_i) begin
        if (addr_i == 0)      m_rd = m_run * 128 + m_ps;
        else if (addr_i == 1) m_rd = m_duty;
        else                  m_rd = 0;
      end
      if (m_run == 0) m_cnt = 0;
      else if (tick_i) begin
        n = m_cnt + 1;
        if ((n / period) % 2 == 1) n = 0;
        m_cnt = n % 256;
      end
      if (wr_en_i && addr_i == 0) begin
        m_run = wdata_i[7]; m_ps = wdata_i[1:0];
      end else if (wr_en_i && addr_i == 1) m_duty = wdata_i[6:0];
    end
  end

  // compare every cycle, away from the active edge; also drive tick
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(req, pwm_o, m_pwm(), "pwm_o");
      check(req, rdata_o, m_rd, "rdata_o");
    end
    tick_i <= (tick_div == 0) ? 1'b0 : ((cyc % tick_div) == 0);
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr_i <= 2'(a); wdata_i <= 8'(d); wr_en_i <= 1'b1;
    @(negedge clk);
    wr_en_i <= 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string r);
    @(negedge clk);
    addr_i <= 2'(a); rd_en_i <= 1'b1;
    @(negedge clk);
    rd_en_i <= 1'b0;
    #1 check(r, rdata_o, exp, "readback");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    #1 check("R1", pwm_o, 0, "pwm after reset");
    check("R1", rdata_o, 0, "rdata after reset");
    rst_n = 1'b1;
    rd(0, 0, "R1"); rd(1, 0, "R1");

    req = "R2"; tick_div = 1;
    wr(1, 40); idle(20);
    #1 check("R2", pwm_o, 0, "idle output");
    wr(0, 8'h80); idle(300);

    req = "R4";
    wr(0, 8'h81); idle(200);
    wr(0, 8'h82); idle(100);
    wr(0, 8'h83); wr(1, 5); idle(60);

    req = "R3"; tick_div = 3; idle(150);
    tick_div = 0; idle(20); tick_div = 7; idle(200); tick_div = 1;

    req = "R5"; wr(1, 0); idle(40);
    #1 check("R5", pwm_o, 0, "zero duty");
    wr(0, 8'h81); wr(1, 63); idle(150);

    req = "R6"; wr(1, 64); idle(100);
    #1 check("R6", pwm_o, 1, "full scale s=1");
    wr(0, 8'h83); wr(1, 100); idle(50);
    wr(0, 8'h80); wr(1, 127); idle(300);

    req = "R7"; wr(0, 8'h82); wr(1, 3); idle(10);
    wr(1, 20); idle(1);
    #1 check("R7", pwm_o, m_pwm(), "duty immediate");
    idle(70);

    req = "R8"; wr(0, 8'h80); wr(1, 50); idle(100);
    wr(0, 8'h83); idle(80); wr(0, 8'h80); idle(90);
    wr(0, 8'h82); idle(70);

    req = "R9"; wr(0, 8'hFE);
    rd(0, 8'h82, "R9"); rd(1, 50, "R9"); rd(2, 0, "R9"); rd(3, 0, "R9");
    rd(1, 50, "R9"); idle(5);
    #1 check("R9", rdata_o, 50, "rdata held");

    req = "R10"; wr(1, 8'hFF);
    rd(1, 127, "R10");
    wr(2, 8'h01); wr(3, 8'h05);
    rd(0, 8'h82, "R10"); rd(1, 127, "R10");
    idle(40);

    req = "R2"; wr(0, 8'h03); idle(20);
    #1 check("R2", pwm_o, 0, "stopped output");
    wr(1, 10); wr(0, 8'h83); idle(40);

    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule